// File: doc/BRIEF.md
# ADC Result Readback Sequencer

This block sits between the byte-level engine of a two-wire serial slave and an abstract multichannel converter. When the serial engine reports that a read address has been acknowledged, the sequencer starts a fresh conversion sequence. The sequence is either one conversion of a selected channel or an ascending scan from channel 0 up to a chosen upper channel. It drives the converter through a start/done handshake and keeps every 10-bit result in a small store. It then hands the results to the byte transmitter as two-byte pairs over a valid/ready stream.

In internal-clock mode the sequencer asks the serial engine to hold the bus clock low until the whole sequence has finished. In external-clock mode it never asks for a stretch, and each result is offered as soon as it has been stored. Reads that go past the last stored result wrap to the first one. No conversion is started again until the next read address. A stop or repeated start after the master's NACK closes the transaction and rewinds the read pointer.

Byte stream rules: `byte_valid` is never raised while `clk_stretch` is high, or while the result at the read pointer has not yet been stored. Once raised, `byte_valid` and `byte_data` hold until a rising edge sees `byte_ready` high, which moves the transfer forward. The only exception is a transaction that is ended or restarted. The transmitter may hold `byte_ready` low for any number of cycles.

Top module: `adc_readout_seq`

## Requirements
- R1: In scan mode the channels 0 up to `cfg_chan` are converted one at a time in ascending order, and the results are served in the order they were converted.
- R2: Each result goes out as two bytes: first `{6'b111111, d[9:8]}`, then `d[7:0]`.
- R3: After the low byte of the last result of a completed sequence, the next byte offered is the high byte of the first result.
- R4: `conv_start` is a one-cycle pulse. Each channel of the sequence gets exactly one pulse per transaction, and there are no pulses outside an active transaction or after the sequence completes.
- R5: In internal-clock mode `clk_stretch` is high from the cycle after `rd_addr_ack` until the cycle after the final `conv_done`, and no byte is offered while it is high.
- R6: In external-clock mode `clk_stretch` stays low, and a byte is offered as soon as its result is stored.
- R7: In scan mode with `cfg_skip_ref` high, channel `REF_CH` (default 11) is left out of the scan.
- R8: In single mode only channel `cfg_chan` is converted, and its result pair is served again on every continued read. `cfg_skip_ref` is ignored in this mode.
- R9: A `xact_end` pulse drops `byte_valid` and `clk_stretch` in the next cycle, and the next read starts at the high byte of its first result.
- R10: While `byte_valid` is high and `byte_ready` is low, `byte_valid` and `byte_data` hold their values.
- R11: After reset, `byte_valid`, `clk_stretch` and `conv_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr_ack | input | 1 | One-cycle pulse: a read address was acknowledged; samples the cfg_* inputs |
| xact_end | input | 1 | One-cycle pulse: stop or repeated start after master NACK |
| cfg_scan | input | 1 | 1 = scan from 0 to cfg_chan, 0 = single conversion |
| cfg_chan | input | CH_W | Scan upper channel or single channel; must be below NUM_CH |
| cfg_skip_ref | input | 1 | Reference pin in use: skip REF_CH in a scan |
| cfg_int_clk | input | 1 | 1 = internal-clock mode (stretch during conversions) |
| conv_start | output | 1 | Converter start pulse |
| conv_ch | output | CH_W | Channel to convert, valid with conv_start |
| conv_done | input | 1 | Converter done pulse, with conv_data |
| conv_data | input | RES_W | Conversion result |
| clk_stretch | output | 1 | Request to hold the bus clock low |
| byte_valid | output | 1 | Result byte offered |
| byte_ready | input | 1 | Transmitter takes the offered byte |
| byte_data | output | 8 | Result byte |

## Verification
`conv_start` rises in the cycle after the edge that samples `rd_addr_ack`. `clk_stretch` rises at that same edge and falls at the edge that stores the final result, so the bench reads both at the falling edge one cycle after the acknowledge and one cycle after the last done pulse. A stored result is offered in the cycle after the storing edge. A byte seen at a falling edge with both valid and ready high has been transferred by the next rising edge, so every byte is compared at the falling edge where the handshake is seen. `xact_end` is checked one falling edge later. The converter model answers each start after a random delay of one to four cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_DONE} sq_state_t;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int REF_CH = 11,
  parameter int CH_W   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            abort,
  input  logic            cfg_scan,
  input  logic [CH_W-1:0] cfg_chan,
  input  logic            cfg_skip_ref,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_ch,
  input  logic            conv_done,
  output logic            wr_en,
  output logic            seq_done
);
  localparam logic [CH_W-1:0] REF_IDX = CH_W'(REF_CH);

  sq_state_t       state;
  logic [CH_W-1:0] cur_ch, last_ch, first_nx, last_nx, step_ch;
  logic            skip_q;

  // first/last channel of the new sequence and the following scan channel
  always_comb begin
    if (cfg_scan) begin
      first_nx = (cfg_skip_ref && REF_IDX == '0) ? CH_W'(1) : '0;
      last_nx  = (cfg_skip_ref && cfg_chan == REF_IDX && cfg_chan != '0)
                 ? cfg_chan - 1'b1 : cfg_chan;
    end else begin
      first_nx = cfg_chan;
      last_nx  = cfg_chan;
    end
    step_ch = cur_ch + 1'b1;
    if (skip_q && step_ch == REF_IDX) step_ch = step_ch + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cur_ch  <= '0;
      last_ch <= '0;
      skip_q  <= 1'b0;
    end else if (start) begin
      state   <= SQ_ISSUE;
      cur_ch  <= first_nx;
      last_ch <= last_nx;
      skip_q  <= cfg_scan && cfg_skip_ref;
    end else if (abort) begin
      state <= SQ_IDLE;
    end else begin
      case (state)
        SQ_ISSUE: state <= SQ_WAIT;
        SQ_WAIT: begin
          if (conv_done) begin
            if (cur_ch == last_ch) begin
              state <= SQ_DONE;
            end else begin
              cur_ch <= step_ch;
              state  <= SQ_ISSUE;
            end
          end
        end
        default: state <= state;
      endcase
    end
  end

  assign conv_start = (state == SQ_ISSUE);
  assign conv_ch    = cur_ch;
  assign wr_en      = (state == SQ_WAIT) && conv_done;
  assign seq_done   = (state == SQ_DONE);
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
  parameter int NUM_CH = 12,
  parameter int RES_W  = 10,
  parameter int CH_W   = 4,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [RES_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] rd_idx,
  output logic [RES_W-1:0] rd_data
);
  logic [RES_W-1:0] mem [NUM_CH];
  logic             room;

  assign room = (count < CNT_W'(NUM_CH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (clear)                 count <= '0;
    else if (wr_en && room)         count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!clear && wr_en && room) mem[count[CH_W-1:0]] <= wr_data;
  end

  assign rd_data = mem[rd_idx[CH_W-1:0]];
endmodule

// File: rtl/adc_byte_server.sv
module adc_byte_server
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              enable,
  input  logic              seq_done,
  input  logic [CNT_W-1:0]  count,
  input  logic [RES_W-1:0]  rd_data,
  output logic [CNT_W-1:0]  rd_idx,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int HI_W  = RES_W - BYTE_W;
  localparam int PAD_W = BYTE_W - HI_W;

  logic [CNT_W-1:0] ptr, eff;
  logic             lo_phase;

  // past the last result of a finished sequence: wrap to the first
  assign eff        = (seq_done && ptr == count) ? '0 : ptr;
  assign rd_idx     = eff;
  assign byte_valid = enable && (eff < count);
  assign byte_data  = lo_phase ? rd_data[BYTE_W-1:0]
                               : {{PAD_W{1'b1}}, rd_data[RES_W-1:BYTE_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      lo_phase <= 1'b0;
    end else if (restart) begin
      ptr      <= '0;
      lo_phase <= 1'b0;
    end else if (byte_valid && byte_ready) begin
      if (lo_phase) begin
        lo_phase <= 1'b0;
        ptr      <= eff + 1'b1;
      end else begin
        lo_phase <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_readout_seq.sv
module adc_readout_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int RES_W  = 10,
  parameter int REF_CH = NUM_CH - 1,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_addr_ack,
  input  logic              xact_end,
  input  logic              cfg_scan,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic              cfg_skip_ref,
  input  logic              cfg_int_clk,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              clk_stretch,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic [BYTE_W-1:0] byte_data
);
  logic             active, int_q, wr_en, seq_done;
  logic [CNT_W-1:0] wr_count, rd_idx;
  logic [RES_W-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      int_q  <= 1'b0;
    end else if (rd_addr_ack) begin
      active <= 1'b1;
      int_q  <= cfg_int_clk;
    end else if (xact_end) begin
      active <= 1'b0;
    end
  end

  assign clk_stretch = active && int_q && !seq_done;

  adc_scan_ctrl #(.NUM_CH(NUM_CH), .REF_CH(REF_CH), .CH_W(CH_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(rd_addr_ack), .abort(xact_end),
    .cfg_scan(cfg_scan), .cfg_chan(cfg_chan), .cfg_skip_ref(cfg_skip_ref),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .wr_en(wr_en), .seq_done(seq_done)
  );

  adc_result_store #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(rd_addr_ack), .wr_en(wr_en),
    .wr_data(conv_data), .count(wr_count), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  adc_byte_server #(.RES_W(RES_W), .CNT_W(CNT_W)) u_server (
    .clk(clk), .rst_n(rst_n), .restart(rd_addr_ack || xact_end),
    .enable(active && !clk_stretch), .seq_done(seq_done), .count(wr_count),
    .rd_data(rd_data), .rd_idx(rd_idx), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .byte_data(byte_data)
  );
endmodule

// File: rtl/adc_readout_seq_chk.sv
module adc_readout_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_addr_ack,
  input logic       xact_end,
  input logic       active,
  input logic       conv_start,
  input logic       clk_stretch,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic [7:0] byte_data
);
  AST_STRETCH_BLOCKS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stretch |-> !byte_valid); // R5
  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready && !xact_end && !rd_addr_ack) |=> (byte_valid && $stable(byte_data))); // R10
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R4
  AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !conv_start); // R4
  AST_END_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_end && !rd_addr_ack) |=> (!byte_valid && !clk_stretch && !conv_start)); // R9
endmodule

bind adc_readout_seq adc_readout_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr_ack(rd_addr_ack), .xact_end(xact_end),
  .active(active), .conv_start(conv_start), .clk_stretch(clk_stretch),
  .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data)
);

// File: tb/adc_readout_seq_test.sv
module adc_readout_seq_test;
  localparam int NCH = 12;
  localparam int REF = 11;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rd_addr_ack = 1'b0, xact_end = 1'b0;
  logic       cfg_scan = 1'b0, cfg_skip_ref = 1'b0, cfg_int_clk = 1'b0;
  logic [3:0] cfg_chan = '0;
  logic       conv_start, conv_done = 1'b0;
  logic [3:0] conv_ch;
  logic [9:0] conv_data = '0;
  logic       clk_stretch, byte_valid, byte_ready = 1'b0;
  logic [7:0] byte_data;

  int checks = 0, errors = 0;
  int salt = 0, start_count = 0, done_count = 0;
  int seen [0:31];
  int exp_ch [0:15];
  int exp_n = 0;

  always #2 clk = ~clk;

  adc_readout_seq uut (
    .clk(clk), .rst_n(rst_n), .rd_addr_ack(rd_addr_ack), .xact_end(xact_end),
    .cfg_scan(cfg_scan), .cfg_chan(cfg_chan), .cfg_skip_ref(cfg_skip_ref),
    .cfg_int_clk(cfg_int_clk), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .clk_stretch(clk_stretch),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data)
  );

  function automatic logic [9:0] conv_val(int ch, int s);
    return 10'((ch * 73 + s * 211 + 5) % 1024);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic build_exp(input bit scan, input int chan, input bit skip);
    exp_n = 0;
    if (!scan) begin
      exp_ch[0] = chan;
      exp_n = 1;
    end else begin
      for (int c = 0; c <= chan; c++) begin
        if (!(skip && c == REF)) begin
          exp_ch[exp_n] = c;
          exp_n++;
        end
      end
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // converter model: answers each start after 1..4 cycles
  initial begin
    int pend = 0;
    int pch = 0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          conv_done = 1'b1;
          conv_data = conv_val(pch, salt);
          done_count++;
        end
      end
      if (conv_start) begin
        if (start_count < 32) seen[start_count] = int'(conv_ch);
        start_count++;
        pch  = int'(conv_ch);
        pend = 1 + int'($urandom % 4);
      end
    end
  end

  task automatic run_txn(input bit scan, input int chan, input bit skip,
                         input bit intclk, input int nbytes, input string tag);
    int k = 0;
    bit ext_str = 1'b0;
    bit stall = 1'b0;
    logic [7:0] stall_data = '0;
    build_exp(scan, chan, skip);
    @(negedge clk);
    start_count = 0;
    done_count  = 0;
    salt        = int'($urandom % 1024);
    cfg_scan = scan; cfg_chan = 4'(chan); cfg_skip_ref = skip; cfg_int_clk = intclk;
    byte_ready  = 1'b0;
    rd_addr_ack = 1'b1;
    @(negedge clk);
    rd_addr_ack = 1'b0;
    if (intclk) begin
      chk(clk_stretch && !byte_valid, {tag, " R5 stretch after ack"}, int'(clk_stretch), 1);
      while (done_count < exp_n) @(negedge clk);
      @(negedge clk);
      chk(!clk_stretch && byte_valid, {tag, " R5 release after last done"}, int'(clk_stretch), 0);
    end else begin
      chk(!clk_stretch, {tag, " R6 no stretch after ack"}, int'(clk_stretch), 0);
    end
    while (k < nbytes) begin
      byte_ready = ($urandom % 4) != 0;
      if (clk_stretch && !intclk) ext_str = 1'b1;
      if (stall && byte_valid)
        chk(byte_data == stall_data, {tag, " R10 hold under stall"}, int'(byte_data), int'(stall_data));
      stall = byte_valid && !byte_ready;
      stall_data = byte_data;
      if (byte_valid && byte_ready) begin
        int p = (k / 2) % exp_n;
        logic [9:0] d = conv_val(exp_ch[p], salt);
        logic [7:0] e = (k % 2 == 0) ? {6'h3F, d[9:8]} : d[7:0];
        string rq = (k / 2 >= exp_n) ? " R3 wrap" : ((k % 2 == 0) ? " R2 high byte" : " R1 order");
        chk(byte_data == e, {tag, rq}, int'(byte_data), int'(e));
        k++;
      end
      @(negedge clk);
    end
    byte_ready = 1'b0;
    if (!intclk) chk(!ext_str, {tag, " R6 stretch stayed low"}, int'(ext_str), 0);
    while (done_count < exp_n) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(start_count == exp_n, {tag, " R4 one start per channel"}, start_count, exp_n);
    for (int i = 0; i < exp_n && i < 32; i++)
      chk(seen[i] == exp_ch[i], {tag, scan ? " R1 R7 scan channel" : " R8 single channel"}, seen[i], exp_ch[i]);
    xact_end = 1'b1;
    @(negedge clk);
    xact_end = 1'b0;
    chk(!byte_valid && !clk_stretch, {tag, " R9 end quiets"}, int'(byte_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!byte_valid && !clk_stretch && !conv_start, "R11 reset outputs", int'(byte_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!byte_valid && !clk_stretch && !conv_start, "R11 idle after reset", int'(conv_start), 0);
    run_txn(1, 11, 1, 1, 26, "R7 skip ref int");
    run_txn(1, 11, 0, 0, 30, "full scan ext");
    run_txn(1, 5, 1, 0, 20, "scan ext");
    run_txn(0, 11, 1, 1, 7, "R8 single on ref");
    run_txn(1, 3, 0, 1, 3, "R9 partial read");
    run_txn(1, 3, 0, 1, 4, "R9 after partial");
    run_txn(1, 0, 0, 1, 5, "scan one channel");
    for (int t = 0; t < 24; t++) begin
      bit sc = ($urandom % 3) != 0;
      int ch = int'($urandom % NCH);
      bit sk = $urandom % 2;
      bit ic = $urandom % 2;
      int n  = sc ? (ch + 1) : 1;
      run_txn(sc, ch, sk, ic, 1 + int'($urandom % (4 * n + 3)), "random");
    end
    finish_run();
  end
endmodule